// File: doc/BRIEF.md
# Oscillator Phase Generator with Octant Symmetry

This block produces the phase stream of a numerically controlled oscillator and rebuilds full-circle sine and cosine samples from a rotation core that only handles the first octant (0 to π/4). On every clock a 16-bit tuning word is added to a 16-bit phase register that wraps modulo 2^16. A 16-bit offset word is then added to form the instantaneous phase, which is registered. The top three phase bits name one of eight octants. The remaining bits become a folded angle, which goes out to the rotation core.

The core is outside this block. It returns unsigned-range first-octant sine and cosine values a fixed number of cycles later, set by the parameter `CORE_LAT` (at least 1). The octant information travels through a matching delay line. When the core results arrive, they are exchanged and sign-corrected according to their own octant and then registered as signed 16-bit outputs. The output frequency is the clock frequency times the tuning word divided by 2^16.

Top module: `nco_phase_fold`

## Requirements
- R1: A synchronous active-high reset clears the phase register, the registered phase, the octant delay line and both outputs. In the cycle after a reset edge, `sin_out`, `cos_out` and `core_angle` are 0.
- R2: At each rising edge that is not a reset edge, the phase register becomes (phase register + `tune_word`) mod 2^16, and the registered phase becomes (old phase register + `offset_word`) mod 2^16.
- R3: `core_angle` (14 bits) is derived combinationally from the registered phase p. It equals p[12:0] when p[13] is 0, and 8192 − p[12:0] when p[13] is 1. Its range is therefore 0 to 8192, where 8192 stands for π/4.
- R4: When p[14] XOR p[13] is 1, the core's cosine result feeds the sine path and the core's sine result feeds the cosine path. Otherwise each result stays on its own path. The exchange is applied before the sign corrections.
- R5: When p[15] is 1, the sine path is negated in two's complement. Otherwise it is passed unchanged.
- R6: When p[15] XOR p[14] is 1, the cosine path is negated in two's complement. Otherwise it is passed unchanged.
- R7: Core results presented in the cycle after edge k+`CORE_LAT` belong to the angle shown after edge k. The corrected output for the phase registered at edge k appears after edge k+`CORE_LAT`+1 and uses that phase's own octant bits.
- R8: With an ideal core, the outputs equal round(32767·sin θ) and round(32767·cos θ) within 1 LSB, where θ = 2π·p/65536. A tuning word W gives a period of 65536/W samples: 0x1999 gives about 10 samples per cycle, and 0x00B6 gives about 360.
- R9: The phase register and the offset addition both wrap modulo 2^16, so tuning words with the top bit set step the phase backwards through 0 without disturbing the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | 16 | Phase increment added every cycle |
| offset_word | input | 16 | Phase offset added after the phase register |
| core_angle | output | 14 | Folded first-octant angle sent to the rotation core |
| core_sin | input | 16 | Signed sine result returned by the core |
| core_cos | input | 16 | Signed cosine result returned by the core |
| sin_out | output | 16 | Signed full-circle sine sample |
| cos_out | output | 16 | Signed full-circle cosine sample |

## Verification
The path exchange and the sign corrections coincide in octants 2, 5 and 6. Octant 5 exercises all three at once. The bench holds the tuning word at zero and sets the offset word to phases inside those octants and exactly on their edges. It then compares both outputs with true trigonometric values, so a correction applied in the wrong order or on the wrong path shows up as a wrong sign or a wrong magnitude. The per-cycle model also tracks the octant that belongs to each sample while the offset changes in consecutive cycles, which catches a delay line that is one stage off.

// File: rtl/nco_fold_pkg.sv
package nco_fold_pkg;

    localparam int PHASE_W_DEF = 16;
    localparam int DATA_W_DEF  = 16;

    // Correction controls derived from the three octant bits
    typedef struct packed {
        logic swap;
        logic neg_sin;
        logic neg_cos;
    } fix_ctl_t;

    function automatic fix_ctl_t decode_octant(input logic [2:0] oct);
        fix_ctl_t c;
        c.swap    = oct[1] ^ oct[0];
        c.neg_sin = oct[2];
        c.neg_cos = oct[2] ^ oct[1];
        return c;
    endfunction

endpackage

// File: rtl/nco_phase_gen.sv
module nco_phase_gen #(
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] tune_word,
    input  logic [PHASE_W-1:0] offset_word,
    output logic [PHASE_W-1:0] phase_q
);
    logic [PHASE_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            phase_q <= '0;
        end else begin
            acc_q   <= acc_q + tune_word;
            phase_q <= acc_q + offset_word;
        end
    end
endmodule

// File: rtl/nco_octant_fold.sv
module nco_octant_fold
    import nco_fold_pkg::*;
#(
    parameter int PHASE_W = 16,
    localparam int RES_W  = PHASE_W - 3,
    localparam int ANG_W  = PHASE_W - 2
) (
    input  logic [PHASE_W-1:0] phase,
    output logic [ANG_W-1:0]   angle,
    output fix_ctl_t           ctl
);
    logic [2:0]       oct;
    logic [RES_W-1:0] resid;
    logic [ANG_W-1:0] quarter_pi;

    assign oct        = phase[PHASE_W-1 -: 3];
    assign resid      = phase[RES_W-1:0];
    assign quarter_pi = {1'b1, {RES_W{1'b0}}};

    always_comb begin
        if (oct[0]) angle = quarter_pi - {1'b0, resid};
        else        angle = {1'b0, resid};
        ctl = decode_octant(oct);
    end
endmodule

// File: rtl/nco_octant_delay.sv
module nco_octant_delay
    import nco_fold_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  fix_ctl_t ctl_in,
    output fix_ctl_t ctl_out
);
    fix_ctl_t stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= ctl_in;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign ctl_out = stage_q[DEPTH-1];
endmodule

// File: rtl/nco_octant_fix.sv
module nco_octant_fix
    import nco_fold_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  fix_ctl_t                 ctl,
    input  logic signed [DATA_W-1:0] core_sin,
    input  logic signed [DATA_W-1:0] core_cos,
    output logic signed [DATA_W-1:0] sin_out,
    output logic signed [DATA_W-1:0] cos_out
);
    logic signed [DATA_W-1:0] s_sel, c_sel, s_nx, c_nx;

    always_comb begin
        s_sel = ctl.swap ? core_cos : core_sin;
        c_sel = ctl.swap ? core_sin : core_cos;
        s_nx  = ctl.neg_sin ? (~s_sel + 1'b1) : s_sel;
        c_nx  = ctl.neg_cos ? (~c_sel + 1'b1) : c_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sin_out <= '0;
            cos_out <= '0;
        end else begin
            sin_out <= s_nx;
            cos_out <= c_nx;
        end
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (sin_out == 0 && cos_out == 0)); // R1

    AST_SWAP_PATH: assert property (@(posedge clk) disable iff (rst)
        ctl.swap |=> (sin_out == $past(core_cos) || sin_out == -$past(core_cos))); // R4

    AST_KEEP_PATH: assert property (@(posedge clk) disable iff (rst)
        !ctl.swap |=> (sin_out == $past(core_sin) || sin_out == -$past(core_sin))); // R4

    AST_SIN_SIGN: assert property (@(posedge clk) disable iff (rst)
        (ctl.neg_sin && core_sin > 0 && core_cos > 0) |=> sin_out < 0); // R5

    AST_COS_SIGN: assert property (@(posedge clk) disable iff (rst)
        (ctl.neg_cos && core_sin > 0 && core_cos > 0) |=> cos_out < 0); // R6
endmodule

// File: rtl/nco_phase_fold.sv
module nco_phase_fold
    import nco_fold_pkg::*;
#(
    parameter int PHASE_W  = PHASE_W_DEF,
    parameter int DATA_W   = DATA_W_DEF,
    parameter int CORE_LAT = 4,
    localparam int ANG_W   = PHASE_W - 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [PHASE_W-1:0]       tune_word,
    input  logic [PHASE_W-1:0]       offset_word,
    output logic [ANG_W-1:0]         core_angle,
    input  logic signed [DATA_W-1:0] core_sin,
    input  logic signed [DATA_W-1:0] core_cos,
    output logic signed [DATA_W-1:0] sin_out,
    output logic signed [DATA_W-1:0] cos_out
);
    logic [PHASE_W-1:0] phase_q;
    fix_ctl_t           ctl_now, ctl_late;

    nco_phase_gen #(.PHASE_W(PHASE_W)) u_gen (
        .clk(clk), .rst(rst), .tune_word(tune_word),
        .offset_word(offset_word), .phase_q(phase_q)
    );

    nco_octant_fold #(.PHASE_W(PHASE_W)) u_fold (
        .phase(phase_q), .angle(core_angle), .ctl(ctl_now)
    );

    nco_octant_delay #(.DEPTH(CORE_LAT)) u_dly (
        .clk(clk), .rst(rst), .ctl_in(ctl_now), .ctl_out(ctl_late)
    );

    nco_octant_fix #(.DATA_W(DATA_W)) u_fix (
        .clk(clk), .rst(rst), .ctl(ctl_late),
        .core_sin(core_sin), .core_cos(core_cos),
        .sin_out(sin_out), .cos_out(cos_out)
    );
endmodule

// File: tb/nco_phase_fold_tb.sv
module nco_phase_fold_tb;
    localparam int CLK_P = 10;
    localparam int LAT   = 4;
    localparam real AMP  = 32767.0;
    localparam real TWO_PI = 6.283185307179586;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tune_word = '0;
    logic [15:0] offset_word = '0;
    logic [13:0] core_angle;
    logic signed [15:0] core_sin, core_cos, sin_out, cos_out;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    nco_phase_fold #(.CORE_LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .tune_word(tune_word), .offset_word(offset_word),
        .core_angle(core_angle), .core_sin(core_sin), .core_cos(core_cos),
        .sin_out(sin_out), .cos_out(cos_out)
    );

    function automatic int rnd(input real x);
        if (x >= 0.0) return $rtoi(x + 0.5);
        return -$rtoi(-x + 0.5);
    endfunction

    // Ideal first-octant core with LAT cycles of latency
    logic signed [15:0] cs_p [LAT];
    logic signed [15:0] cc_p [LAT];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) begin cs_p[i] <= 0; cc_p[i] <= 0; end
        end else begin
            cs_p[0] <= 16'(rnd(AMP * $sin(real'(core_angle) * TWO_PI / 65536.0)));
            cc_p[0] <= 16'(rnd(AMP * $cos(real'(core_angle) * TWO_PI / 65536.0)));
            for (int i = 1; i < LAT; i++) begin cs_p[i] <= cs_p[i-1]; cc_p[i] <= cc_p[i-1]; end
        end
    end
    assign core_sin = cs_p[LAT-1];
    assign core_cos = cc_p[LAT-1];

    // Behavioural reference
    int q_s[$], q_c[$];
    int m_acc = 0, m_ph = 0, exp_s = 0, exp_c = 0, exp_a = 0;

    function automatic int fold_ref(input int ph);
        int r;
        r = ph % 8192;
        if (((ph / 8192) % 2) == 1) return 8192 - r;
        return r;
    endfunction

    task automatic model_edge();
        if (rst) begin
            q_s.delete(); q_c.delete();
            for (int i = 0; i < LAT; i++) begin q_s.push_back(0); q_c.push_back(0); end
            exp_s = 0; exp_c = 0; m_acc = 0; m_ph = 0;
        end else begin
            exp_s = q_s.pop_front();
            exp_c = q_c.pop_front();
            q_s.push_back(rnd(AMP * $sin(real'(m_ph) * TWO_PI / 65536.0)));
            q_c.push_back(rnd(AMP * $cos(real'(m_ph) * TWO_PI / 65536.0)));
            m_ph  = (m_acc + int'(offset_word)) % 65536;
            m_acc = (m_acc + int'(tune_word)) % 65536;
        end
        exp_a = fold_ref(m_ph);
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic tick(input string tag);
        model_edge();
        @(posedge clk);
        #1;
        n_run++;
        if (iabs(int'(sin_out) - exp_s) > 1 || iabs(int'(cos_out) - exp_c) > 1 ||
            int'(core_angle) != exp_a) begin
            n_fail++;
            $display("FAIL %s sin=%0d cos=%0d ang=%0d expected sin=%0d cos=%0d ang=%0d",
                     tag, sin_out, cos_out, core_angle, exp_s, exp_c, exp_a);
        end
    endtask

    task automatic hold_phase(input int ph, input string tag);
        tune_word = 16'd0;
        offset_word = 16'(ph);
        for (int i = 0; i < LAT + 3; i++) tick(tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int crossings;
        int prev_s;
        // R1: reset state
        rst = 1'b1;
        tick("R1 reset");
        tick("R1 reset");
        rst = 1'b0;
        for (int i = 0; i < LAT + 2; i++) tick("R1 idle after reset");

        // R3: fold edges, R4/R5/R6 each octant and boundaries
        hold_phase(16'h0000, "R3 zero angle");
        hold_phase(16'h1FFF, "R3 top of octant 0");
        hold_phase(16'h2000, "R3 reflect to pi/4");
        hold_phase(16'h3000, "R4 octant 1");
        hold_phase(16'h4800, "R4 R6 octant 2");
        hold_phase(16'h6800, "R6 octant 3");
        hold_phase(16'h8000, "R5 R6 half circle");
        hold_phase(16'h9000, "R5 R6 octant 4");
        hold_phase(16'hA800, "R4 R5 R6 octant 5");
        hold_phase(16'hC800, "R4 R5 octant 6");
        hold_phase(16'hE800, "R5 octant 7");
        hold_phase(16'hFFFF, "R3 last code");

        // R7: offset changing every cycle, octants must follow their samples
        tune_word = 16'd0;
        for (int i = 0; i < 64; i++) begin
            offset_word = 16'(i * 16'h1357);
            tick("R7 per-sample octant");
        end

        // R2/R8: ramp with tuning word 0x1999, count rising zero crossings
        rst = 1'b1; tick("R1 mid reset"); rst = 1'b0;
        tune_word = 16'h1999; offset_word = 16'h0000;
        for (int i = 0; i < LAT + 2; i++) tick("R2 ramp start");
        crossings = 0; prev_s = int'(sin_out);
        for (int i = 0; i < 400; i++) begin
            tick("R2 ramp 0x1999");
            if (prev_s < 0 && int'(sin_out) >= 0) crossings++;
            prev_s = int'(sin_out);
        end
        n_run++;
        if (crossings < 39 || crossings > 41) begin
            n_fail++;
            $display("FAIL R8 crossings=%0d expected 40", crossings);
        end

        // R8: slow word 0x00B6 with an offset
        tune_word = 16'h00B6; offset_word = 16'h1234;
        crossings = 0; prev_s = int'(sin_out);
        for (int i = 0; i < 1440; i++) begin
            tick("R8 ramp 0x00B6");
            if (prev_s < 0 && int'(sin_out) >= 0) crossings++;
            prev_s = int'(sin_out);
        end
        n_run++;
        if (crossings < 3 || crossings > 5) begin
            n_fail++;
            $display("FAIL R8 crossings=%0d expected 4", crossings);
        end

        // R9: backwards stepping and wrap through zero with offset
        tune_word = 16'hFF01; offset_word = 16'hF000;
        for (int i = 0; i < 600; i++) tick("R9 wrap backwards");
        tune_word = 16'h8001; offset_word = 16'h0003;
        for (int i = 0; i < 40; i++) tick("R9 half-step wrap");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule